// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the bus-facing side of a small serial EEPROM holding 256 bytes. A fast system clock samples the two-wire bus lines through a two-stage synchronizer. The block finds START and STOP conditions and shifts bits in and out on the data line. It also decodes the addressing byte and runs the write and read flows against an internal byte array.

The chip address is a fixed type code plus three strap pins. A busy input from the nonvolatile write engine makes the block refuse its addressing byte, so a master can poll until the write finishes. The block starts that engine with a one-cycle pulse when a STOP closes a write that carried data. Reads begin at an internal address counter. Repeated acknowledges from the master stream successive bytes.

Top module: `eeprom_slave`

## Requirements
- R1: While reset is applied, and right after it, `sda_oe_o` and `wr_start_o` are low.
- R2: A falling data line while the clock is high (START) restarts address matching from any point, including mid-byte. A rising data line while the clock is high (STOP) returns the engine to idle. A transfer cut off either way leaves the address counter and memory untouched.
- R3: The slave acknowledges an addressing byte by pulling the data line low on the ninth clock only when bits 7..4 are 1010 and bits 3..1 equal `strap_i[2:0]`. Bit 0 high selects read and low selects write. Any other byte is not acknowledged.
- R4: When `wr_busy_i` is high at the acknowledge decision, a matching addressing byte is not acknowledged. Once it is low, the same byte is acknowledged.
- R5: In a write, the byte after the addressing byte loads the word address. Each later data byte is stored at the counter. Every byte is acknowledged.
- R6: `wr_start_o` pulses high for one cycle on a STOP that follows at least one completed data byte. A write holding only the word address (a dummy write) produces no pulse.
- R7: During a write, only the low 3 bits of the counter advance after each data byte and wrap within an 8-byte page. The upper 5 bits stay fixed, so extra bytes overwrite the page from its start.
- R8: A current-address read returns the byte one past the last location read or written.
- R9: A random read (dummy write of the word address, repeated START, read addressing byte) returns the byte at that word address.
- R10: In a read, each master acknowledge (data low on the ninth clock) sends the next byte. The counter wraps from 255 to 0. A master non-acknowledge ends the read with the line released.
- R11: `sda_oe_o` changes only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| strap_i | input | 3 | Chip-select strap pins, compared with addressing byte bits 3..1 |
| wr_busy_i | input | 1 | High while the nonvolatile write cycle runs |
| sda_oe_o | output | 1 | High pulls the data line low (open drain) |
| wr_start_o | output | 1 | One-cycle pulse that starts the write cycle |

## Verification
The assertions assume the master changes the data line only while the clock is low, except when it makes START or STOP. They also assume the master never makes START or STOP while the slave holds the line low, so edges seen on the synchronized clock follow the bus order. The bench drives the clock and data line at separate quarter periods of ten system cycles each. It models the line as wired-AND of the master and the slave. It issues START and STOP only at points where the slave has released the line.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } eng_state_e;

  localparam logic [3:0] TYPE_CODE = 4'b1010;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_q, sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_ff[STAGES-1];
      sda_q <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // data edge while clock held high on both samples
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/eeprom_mem.sv
module eeprom_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/eeprom_slave.sv
module eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int PAGE_BITS = 3,
  parameter int STRAP_W   = 3,
  parameter int SYNC_N    = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               wr_busy_i,
  output logic               sda_oe_o,
  output logic               wr_start_o
);
  localparam int CNT_W = $clog2(DW + 2);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DW);
  localparam logic [CNT_W-1:0] BIT_ACK  = CNT_W'(DW + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  bus_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  eng_state_e       state_q;
  logic [CNT_W-1:0] bit_q;
  logic [DW-1:0]    rx_q, tx_q;
  logic [AW-1:0]    ptr_q, page_next;
  logic             mack_q, wr_pend_q, wr_start_q, oe_q;
  logic             dev_hit, mem_we;
  logic [DW-1:0]    mem_rd;

  assign dev_hit = (rx_q[DW-1 -: 4] == TYPE_CODE) &&
                   (rx_q[STRAP_W:1] == strap_i) && !wr_busy_i;

  assign page_next = {ptr_q[AW-1:PAGE_BITS],
                      ptr_q[PAGE_BITS-1:0] + PAGE_BITS'(1)};

  assign mem_we = !start_det && !stop_det && scl_fall &&
                  (state_q == ST_WDATA) && (bit_q == BIT_LAST);

  eeprom_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (ptr_q),
    .wdata_i (rx_q),
    .raddr_i (ptr_q),
    .rdata_o (mem_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      ptr_q      <= '0;
      mack_q     <= 1'b1;
      wr_pend_q  <= 1'b0;
      wr_start_q <= 1'b0;
      oe_q       <= 1'b0;
    end else begin
      wr_start_q <= 1'b0;
      if (start_det) begin
        state_q   <= ST_DEV;
        bit_q     <= '0;
        oe_q      <= 1'b0;
        wr_pend_q <= 1'b0;
      end else if (stop_det) begin
        state_q    <= ST_IDLE;
        bit_q      <= '0;
        oe_q       <= 1'b0;
        wr_start_q <= wr_pend_q;
        wr_pend_q  <= 1'b0;
      end else if (state_q != ST_IDLE) begin
        if (scl_rise) begin
          if (bit_q < BIT_LAST) begin
            rx_q  <= {rx_q[DW-2:0], sda_s};
            bit_q <= bit_q + CNT_W'(1);
          end else if (bit_q == BIT_LAST) begin
            mack_q <= sda_s;
            bit_q  <= BIT_ACK;
          end
        end else if (scl_fall) begin
          if (bit_q == BIT_LAST) begin
            // start of ninth clock: acknowledge or release
            unique case (state_q)
              ST_DEV:            oe_q <= dev_hit;
              ST_ADDR, ST_WDATA: oe_q <= 1'b1;
              default:           oe_q <= 1'b0;
            endcase
            if (state_q == ST_ADDR) ptr_q <= rx_q[AW-1:0];
            if (state_q == ST_WDATA) begin
              ptr_q     <= page_next;
              wr_pend_q <= 1'b1;
            end
          end else if (bit_q == BIT_ACK) begin
            bit_q <= '0;
            oe_q  <= 1'b0;
            unique case (state_q)
              ST_DEV: begin
                if (!oe_q) begin
                  state_q <= ST_IDLE;
                end else if (rx_q[0]) begin
                  state_q <= ST_RDATA;
                  tx_q    <= mem_rd;
                  ptr_q   <= ptr_q + AW'(1);
                  oe_q    <= ~mem_rd[DW-1];
                end else begin
                  state_q <= ST_ADDR;
                end
              end
              ST_ADDR:  state_q <= ST_WDATA;
              ST_RDATA: begin
                if (!mack_q) begin
                  tx_q  <= mem_rd;
                  ptr_q <= ptr_q + AW'(1);
                  oe_q  <= ~mem_rd[DW-1];
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              default: ;
            endcase
          end else if (state_q == ST_RDATA && bit_q != '0) begin
            tx_q <= {tx_q[DW-2:0], 1'b0};
            oe_q <= ~tx_q[DW-2];
          end
        end
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign wr_start_o = wr_start_q;
endmodule

// File: rtl/eeprom_slave_chk.sv
module eeprom_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe_o,
  input logic wr_start_o
);
  p_oe_scl_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);

  p_wr_start_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start_o |=> !wr_start_o);

  p_wr_start_after_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start_o |-> $past(stop_det));

  p_start_releases_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe_o);

  p_stop_releases_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o && !$past(wr_start_o));

  // R1: outputs quiet while reset is held
  always_comb begin
    if (!rst_ni) begin
      a_reset_quiet_r1: assert (!sda_oe_o && !wr_start_o);
    end
  end
endmodule

bind eeprom_slave eeprom_slave_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_s      (scl_s),
  .start_det  (start_det),
  .stop_det   (stop_det),
  .sda_oe_o   (sda_oe_o),
  .wr_start_o (wr_start_o)
);

// File: tb/eeprom_slave_test.sv
module eeprom_slave_test;
  localparam int Q = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};
  // {word address, data}
  localparam logic [15:0] VEC [8] = '{
    16'h00_3C, 16'h01_A5, 16'h2B_00, 16'h7F_FF,
    16'h80_5A, 16'hC3_81, 16'hFE_11, 16'hFF_22
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic busy = 1'b0;
  logic sda_oe, wr_start, sda_bus;
  int   n_run = 0, n_fail = 0, wr_cnt = 0, oe_bad = 0;
  logic oe_prev = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  eeprom_slave uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .strap_i    (STRAP),
    .wr_busy_i  (busy),
    .sda_oe_o   (sda_oe),
    .wr_start_o (wr_start)
  );

  always @(negedge clk) begin
    if (wr_start) wr_cnt++;
    if (scl_m && sda_oe != oe_prev) oe_bad++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    scl_m = 1'b0; qw(); sda_m = 1'b1; qw();
    scl_m = 1'b1; qw(); sda_m = 1'b0; qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; sda_m = 1'b0; qw();
    scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qw();
    scl_m = 1'b1; qw(); qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; qw();
    scl_m = 1'b1; qw();
    ack = ~sda_bus; qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic recv_byte(input logic mnack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; qw();
      scl_m = 1'b1; qw();
      d[i] = sda_bus; qw();
      scl_m = 1'b0; qw();
    end
    send_bit(mnack);
    sda_m = 1'b1;
  endtask

  task automatic read_random(input logic [7:0] a, output logic [7:0] d, input string tag);
    logic ack;
    bus_start(); send_byte(DEV_W, ack); chk({tag, " dev ack"}, ack, 1);
    send_byte(a, ack); chk({tag, " addr ack"}, ack, 1);
    bus_start(); send_byte(DEV_R, ack); chk({tag, " read ack"}, ack, 1);
    recv_byte(1'b1, d); bus_stop();
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    int w0;
    repeat (4) @(negedge clk);
    chk("R1 oe in reset", sda_oe, 0);
    chk("R1 wr_start in reset", wr_start, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 oe after reset", sda_oe, 0);

    // R5 R6 byte writes from the table
    for (int i = 0; i < 8; i++) begin
      w0 = wr_cnt;
      bus_start();
      send_byte(DEV_W, ack);         chk("R3 write dev ack", ack, 1);
      send_byte(VEC[i][15:8], ack);  chk("R5 word addr ack", ack, 1);
      send_byte(VEC[i][7:0], ack);   chk("R5 data ack", ack, 1);
      bus_stop(); qw();
      chk("R6 one write pulse", wr_cnt - w0, 1);
    end

    // R9 random reads, R6 dummy writes start no cycle
    w0 = wr_cnt;
    for (int i = 0; i < 8; i++) begin
      read_random(VEC[i][15:8], d, "R9");
      chk("R9 random read data", d, VEC[i][7:0]);
    end
    qw();
    chk("R6 no pulse for dummy writes", wr_cnt, w0);

    // R8 current address read: last read 0xFF, counter now 0x00
    bus_start(); send_byte(DEV_R, ack); chk("R8 dev ack", ack, 1);
    recv_byte(1'b1, d); bus_stop();
    chk("R8 current read data", d, 8'h3C);

    // R10 sequential read wrapping 0xFF -> 0x00
    bus_start(); send_byte(DEV_W, ack); send_byte(8'hFE, ack);
    bus_start(); send_byte(DEV_R, ack); chk("R10 dev ack", ack, 1);
    recv_byte(1'b0, d); chk("R10 seq byte0", d, 8'h11);
    recv_byte(1'b0, d); chk("R10 seq byte1", d, 8'h22);
    recv_byte(1'b0, d); chk("R10 seq wrap byte", d, 8'h3C);
    recv_byte(1'b1, d); chk("R10 seq last", d, 8'hA5);
    qw();
    chk("R10 line released after nack", sda_oe, 0);
    bus_stop();

    // R3 address mismatch
    bus_start(); send_byte({4'b1010, 3'b100, 1'b1}, ack); bus_stop();
    chk("R3 strap mismatch nack", ack, 0);
    bus_start(); send_byte({4'b1011, STRAP, 1'b1}, ack); bus_stop();
    chk("R3 type mismatch nack", ack, 0);

    // R4 busy polling
    busy = 1'b1;
    bus_start(); send_byte(DEV_W, ack); bus_stop();
    chk("R4 busy nack", ack, 0);
    busy = 1'b0;
    w0 = wr_cnt;
    bus_start(); send_byte(DEV_W, ack); bus_stop();
    chk("R4 ack after busy", ack, 1);
    qw();
    chk("R6 no pulse without data", wr_cnt, w0);

    // R7 page write of 10 bytes from 0x16 wraps inside 0x10..0x17
    w0 = wr_cnt;
    bus_start(); send_byte(DEV_W, ack); send_byte(8'h16, ack);
    for (int i = 0; i < 10; i++) begin
      send_byte(8'h40 + 8'(i), ack);
      chk("R7 page data ack", ack, 1);
    end
    bus_stop(); qw();
    chk("R7 page write pulse", wr_cnt - w0, 1);
    bus_start(); send_byte(DEV_W, ack); send_byte(8'h10, ack);
    bus_start(); send_byte(DEV_R, ack);
    for (int i = 0; i < 8; i++) begin
      recv_byte(i == 7, d);
      chk("R7 page content", d, 8'h42 + 8'(i));
    end
    bus_stop();

    // R2 aborts: STOP mid-byte, START mid-byte
    read_random(8'h00, d, "R2");
    chk("R2 setup read", d, 8'h3C);
    bus_start(); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_stop();
    bus_start(); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    bus_start(); send_byte(DEV_R, ack);
    chk("R2 ack after mid-byte start", ack, 1);
    recv_byte(1'b1, d); bus_stop();
    chk("R2 counter kept across aborts", d, 8'hA5);

    qw();
    chk("R11 oe stable while clock high", oe_bad, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule